// File: doc/BRIEF.md
# NAND Cache Program Sequencer

This block is the host side of a multi-page cache program on an 8-bit NAND flash bus. It takes a stream of page requests, each with a row address and a flag that marks the last page of the run, plus a separate byte stream with the page contents. For every page it drives the setup command, five address cycles (two zero column bytes, then the row, low byte first) and `PAGE_BYTES` data cycles. It closes a non-final page with the cache-confirm command 15h and the final page with the true program command 10h.

After each confirm the sequencer waits for the ready/busy pin, issues the status command 70h and one read strobe, and repeats this until the status byte shows the required readiness. Flash results come back late and in two steps. Status bit 1 reports the page before the current one once the cache is ready. Status bit 0 reports the current page only once the array is idle. The sequencer therefore retires each page one step after it issues it, and it drops the invalid bit 1 that follows the first page of a run. Every result leaves through a valid/ready stream as a row and a pass flag, in issue order.

A cycle counter guards every busy wait. If the wait lasts as long as the programmable limit, the sequencer raises a sticky error flag and stops driving the bus.

Top module: `nand_cache_prog_seq`

## Requirements
- R1: After reset, req_ready is 1, and res_valid, tmo_err, fl_wr and fl_rd are 0.
- R2: Each page starts with a write of 80h with fl_cle set. Five writes with fl_ale set follow, carrying 00h, 00h and then row bits [7:0], [15:8] and [23:16]. Then come exactly PAGE_BYTES data writes (fl_cle and fl_ale both low), which carry the bytes from the data stream in the order received.
- R3: A page with req_last = 0 ends with a write of 15h with fl_cle set. A page with req_last = 1 ends with 10h.
- R4: After a confirm, no status command is sent while fl_rb is 0. Each poll is one write of 70h with fl_cle set, followed in the next cycle by exactly one fl_rd cycle, and fl_dq_i is sampled in that fl_rd cycle.
- R5: After a 15h, the next page's 80h is sent only after a status read in which bit 6 (cache ready) is 1.
- R6: The status read that completes the first page of a run (bit 6 = 1) emits no result. For every later page, the earlier page's result uses status bit 1, and a value of 0 means pass.
- R7: After 10h, polling continues until bits 6 and 5 are both 1. The sequencer then emits the previous page's result (from bit 1, if a previous page exists) and then the final page's result (from bit 0, 0 = pass).
- R8: Exactly one result per page is emitted, in issue order, and none is lost while res_ready is held low.
- R9: While res_valid is 1 and res_ready is 0, res_valid, res_row and res_pass stay unchanged.
- R10: If a busy wait (from the confirm until the status condition is met) reaches tmo_limit cycles, tmo_err rises and stays 1. After that, req_ready stays 0 and no write or read strobe is driven until reset.
- R11: fl_wr and fl_rd are never high together, and fl_cle and fl_ale are never high together.
- R12: A run of a single page (req_last = 1 on its first page) is confirmed with 10h and yields exactly one result, taken from status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Page request valid |
| req_ready | output | 1 | Sequencer can accept a page request |
| req_row | input | ROW_W | Row address of the page |
| req_last | input | 1 | Page is the last one of the run |
| dat_valid | input | 1 | Data byte valid |
| dat_ready | output | 1 | Sequencer takes a data byte this cycle if valid |
| dat_byte | input | 8 | Page data byte |
| fl_cle | output | 1 | Command latch enable for the current write |
| fl_ale | output | 1 | Address latch enable for the current write |
| fl_wr | output | 1 | Write strobe, one cycle per bus write |
| fl_rd | output | 1 | Read strobe, one cycle per status read |
| fl_dq_o | output | 8 | Byte driven onto the flash I/O |
| fl_dq_oe | output | 1 | Output enable for fl_dq_o |
| fl_dq_i | input | 8 | Byte read from the flash I/O |
| fl_rb | input | 1 | Ready/busy pin, 1 = ready |
| res_valid | output | 1 | Page result valid |
| res_ready | input | 1 | Consumer accepts the result |
| res_row | output | ROW_W | Row address of the retired page |
| res_pass | output | 1 | 1 = page programmed successfully |
| tmo_limit | input | TMO_W | Busy-wait cycle limit |
| tmo_err | output | 1 | Sticky timeout error |

## Verification
Several properties are checked on every cycle: the strobes never overlap, a read strobe always follows a 70h write, an address phase always follows a setup command, the final confirm belongs to a page flagged last, results hold while stalled, the result queue never overflows, and the timeout flag is sticky and silences the bus. Only the bench scenarios can show the staggered retirement. That covers dropping the invalid first report, matching bit 1 and bit 0 to the right rows across runs of one, two, four and six pages, and ordering under result back-pressure and data gaps. The bench's flash model also checks the address and data bytes, the choice of confirm code, and that a new page begins only after cache ready was read.

// File: rtl/nand_cp_pkg.sv
package nand_cp_pkg;
  localparam logic [7:0] CMD_SETUP = 8'h80;
  localparam logic [7:0] CMD_CACHE = 8'h15;
  localparam logic [7:0] CMD_PROG  = 8'h10;
  localparam logic [7:0] CMD_STAT  = 8'h70;

  localparam int SB_CUR   = 0;
  localparam int SB_PREV  = 1;
  localparam int SB_ARRAY = 5;
  localparam int SB_CACHE = 6;

  localparam int ADDR_CYCLES = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_DATA, S_CONF, S_WAITRB,
    S_STCMD, S_STRD, S_STEVAL, S_RETP, S_RETC, S_HALT
  } seq_st_e;
endpackage

// File: rtl/nand_cp_wdog.sv
module nand_cp_wdog #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [TMO_W-1:0] limit,
  output logic             expire,
  output logic             tmo_err
);
  logic [TMO_W-1:0] cnt;

  assign expire = active && !tmo_err && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      tmo_err <= 1'b0;
    end else begin
      if (!active)
        cnt <= '0;
      else if (cnt != {TMO_W{1'b1}})
        cnt <= cnt + 1'b1;
      if (expire)
        tmo_err <= 1'b1;
    end
  end

  // R10: once raised the error never clears
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    tmo_err |=> tmo_err);
  // R10: the count restarts whenever no wait is in progress
  a_r10_cnt_restart: assert property (@(posedge clk) disable iff (rst)
    !active |=> cnt == '0);
endmodule

// File: rtl/nand_cp_resq.sv
module nand_cp_resq #(
  parameter int ROW_W = 24,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [ROW_W-1:0] push_row,
  input  logic             push_pass,
  output logic             full,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ROW_W-1:0] out_row,
  output logic             out_pass
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = ROW_W + 1;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          load;

  assign full = (cnt == CW'(DEPTH));
  assign load = (cnt != '0) && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (push)
      mem[wp] <= {push_row, push_pass};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_row   <= '0;
      out_pass  <= 1'b0;
    end else begin
      if (push)
        wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (load) begin
        rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        {out_row, out_pass} <= mem[rp];
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      cnt <= cnt + CW'(push) - CW'(load);
    end
  end

  // R8: the sequencer never writes into a full queue
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  a_r8_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R9: a stalled result holds still
  a_r9_res_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_row) && $stable(out_pass)));
endmodule

// File: rtl/nand_cp_fsm.sv
module nand_cp_fsm
  import nand_cp_pkg::*;
#(
  parameter int ROW_W      = 24,
  parameter int PAGE_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_row,
  input  logic             req_last,
  output logic             req_ready,
  input  logic             dat_valid,
  input  logic [7:0]       dat_byte,
  output logic             dat_ready,
  input  logic             fl_rb,
  input  logic [7:0]       fl_dq_i,
  output logic             bus_cle,
  output logic             bus_ale,
  output logic             bus_wr,
  output logic             bus_rd,
  output logic [7:0]       bus_dq,
  output logic             push,
  output logic [ROW_W-1:0] push_row,
  output logic             push_pass,
  input  logic             q_full,
  output logic             busy_win,
  input  logic             expire
);
  localparam int CNT_MAX = (PAGE_BYTES > ADDR_CYCLES) ? PAGE_BYTES : ADDR_CYCLES;
  localparam int IDX_W   = $clog2(CNT_MAX);

  seq_st_e          st;
  logic [IDX_W-1:0] idx;
  logic [ROW_W-1:0] cur_row, prev_row;
  logic             cur_last, prev_v;
  logic             sb_prev, sb_cur;
  logic [23:0]      row_pad;
  logic [7:0]       addr_byte;
  logic             stat_ok;

  always_comb begin
    row_pad = '0;
    row_pad[ROW_W-1:0] = cur_row;
    case (idx)
      IDX_W'(0), IDX_W'(1): addr_byte = 8'h00;
      IDX_W'(2):            addr_byte = row_pad[7:0];
      IDX_W'(3):            addr_byte = row_pad[15:8];
      default:              addr_byte = row_pad[23:16];
    endcase
  end

  assign stat_ok   = fl_dq_i[SB_CACHE] && (!cur_last || fl_dq_i[SB_ARRAY]);
  assign req_ready = (st == S_IDLE);
  assign dat_ready = (st == S_DATA);
  assign busy_win  = (st == S_WAITRB) || (st == S_STCMD) ||
                     (st == S_STRD)   || (st == S_STEVAL);
  assign push      = ((st == S_RETP) || (st == S_RETC)) && !q_full;
  assign push_row  = (st == S_RETP) ? prev_row : cur_row;
  assign push_pass = (st == S_RETP) ? !sb_prev : !sb_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      idx      <= '0;
      cur_row  <= '0;
      cur_last <= 1'b0;
      prev_row <= '0;
      prev_v   <= 1'b0;
      sb_prev  <= 1'b0;
      sb_cur   <= 1'b0;
      bus_cle  <= 1'b0;
      bus_ale  <= 1'b0;
      bus_wr   <= 1'b0;
      bus_rd   <= 1'b0;
      bus_dq   <= '0;
    end else begin
      bus_cle <= 1'b0;
      bus_ale <= 1'b0;
      bus_wr  <= 1'b0;
      bus_rd  <= 1'b0;
      if (expire) begin
        st <= S_HALT;
      end else begin
        case (st)
          S_IDLE: if (req_valid) begin
            cur_row  <= req_row;
            cur_last <= req_last;
            bus_wr   <= 1'b1;
            bus_cle  <= 1'b1;
            bus_dq   <= CMD_SETUP;
            idx      <= '0;
            st       <= S_ADDR;
          end
          S_ADDR: begin
            bus_wr  <= 1'b1;
            bus_ale <= 1'b1;
            bus_dq  <= addr_byte;
            if (idx == IDX_W'(ADDR_CYCLES - 1)) begin
              idx <= '0;
              st  <= S_DATA;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          S_DATA: if (dat_valid) begin
            bus_wr <= 1'b1;
            bus_dq <= dat_byte;
            if (idx == IDX_W'(PAGE_BYTES - 1)) begin
              idx <= '0;
              st  <= S_CONF;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          S_CONF: begin
            bus_wr  <= 1'b1;
            bus_cle <= 1'b1;
            bus_dq  <= cur_last ? CMD_PROG : CMD_CACHE;
            st      <= S_WAITRB;
          end
          S_WAITRB: if (fl_rb) st <= S_STCMD;
          S_STCMD: begin
            bus_wr  <= 1'b1;
            bus_cle <= 1'b1;
            bus_dq  <= CMD_STAT;
            st      <= S_STRD;
          end
          S_STRD: begin
            bus_rd <= 1'b1;
            st     <= S_STEVAL;
          end
          S_STEVAL: begin
            sb_prev <= fl_dq_i[SB_PREV];
            sb_cur  <= fl_dq_i[SB_CUR];
            if (!stat_ok)
              st <= S_WAITRB;
            else if (prev_v)
              st <= S_RETP;
            else if (cur_last)
              st <= S_RETC;
            else begin
              prev_row <= cur_row;
              prev_v   <= 1'b1;
              st       <= S_IDLE;
            end
          end
          S_RETP: if (!q_full) begin
            if (cur_last)
              st <= S_RETC;
            else begin
              prev_row <= cur_row;
              st       <= S_IDLE;
            end
          end
          S_RETC: if (!q_full) begin
            prev_v <= 1'b0;
            st     <= S_IDLE;
          end
          default: st <= S_HALT;
        endcase
      end
    end
  end

  // R11: strobes and latch enables never overlap
  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd) && !(bus_cle && bus_ale));
  // R4: a read strobe always follows a status command
  a_r4_read_after_stat: assert property (@(posedge clk) disable iff (rst)
    bus_rd |-> $past(bus_wr && bus_cle && bus_dq == CMD_STAT));
  // R2: an address phase always opens right after the setup command
  a_r2_addr_after_setup: assert property (@(posedge clk) disable iff (rst)
    (bus_ale && !$past(bus_ale)) |-> $past(bus_wr && bus_cle && bus_dq == CMD_SETUP));
  // R3: the true program command belongs to a page flagged last
  a_r3_final_code: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_cle && bus_dq == CMD_PROG) |-> cur_last);
  // R10: timeout stops the sequencer and the bus
  a_r10_expire_halts: assert property (@(posedge clk) disable iff (rst)
    expire |=> (st == S_HALT) && !bus_wr && !bus_rd);
endmodule

// File: rtl/nand_cache_prog_seq.sv
module nand_cache_prog_seq #(
  parameter int ROW_W      = 24,
  parameter int PAGE_BYTES = 8,
  parameter int RES_DEPTH  = 4,
  parameter int TMO_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic             req_last,
  input  logic             dat_valid,
  output logic             dat_ready,
  input  logic [7:0]       dat_byte,
  output logic             fl_cle,
  output logic             fl_ale,
  output logic             fl_wr,
  output logic             fl_rd,
  output logic [7:0]       fl_dq_o,
  output logic             fl_dq_oe,
  input  logic [7:0]       fl_dq_i,
  input  logic             fl_rb,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [ROW_W-1:0] res_row,
  output logic             res_pass,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             tmo_err
);
  logic             push, push_pass, q_full, busy_win, expire;
  logic [ROW_W-1:0] push_row;

  assign fl_dq_oe = fl_wr;

  nand_cp_fsm #(.ROW_W(ROW_W), .PAGE_BYTES(PAGE_BYTES)) u_fsm (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_row(req_row), .req_last(req_last), .req_ready(req_ready),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_ready(dat_ready),
    .fl_rb(fl_rb), .fl_dq_i(fl_dq_i),
    .bus_cle(fl_cle), .bus_ale(fl_ale), .bus_wr(fl_wr), .bus_rd(fl_rd), .bus_dq(fl_dq_o),
    .push(push), .push_row(push_row), .push_pass(push_pass), .q_full(q_full),
    .busy_win(busy_win), .expire(expire)
  );

  nand_cp_resq #(.ROW_W(ROW_W), .DEPTH(RES_DEPTH)) u_resq (
    .clk(clk), .rst(rst),
    .push(push), .push_row(push_row), .push_pass(push_pass), .full(q_full),
    .out_valid(res_valid), .out_ready(res_ready), .out_row(res_row), .out_pass(res_pass)
  );

  nand_cp_wdog #(.TMO_W(TMO_W)) u_wdog (
    .clk(clk), .rst(rst), .active(busy_win), .limit(tmo_limit),
    .expire(expire), .tmo_err(tmo_err)
  );
endmodule

// File: tb/tb_nand_cache_prog_seq.sv
module tb_nand_cache_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 24;
  localparam int PB    = 8;
  localparam int CB    = 6;
  localparam int PROG  = 20;
  localparam int MAX_CYC = 150000;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_last = 0, dat_valid = 1, res_ready = 1;
  logic [ROW_W-1:0] req_row = '0;
  logic [7:0] dat_byte;
  logic [15:0] tmo_limit = 16'd1000;
  logic req_ready, dat_ready, fl_cle, fl_ale, fl_wr, fl_rd, fl_dq_oe, fl_rb;
  logic [7:0] fl_dq_o, fl_dq_i;
  logic res_valid, res_pass, tmo_err;
  logic [ROW_W-1:0] res_row;

  int total = 0, bad = 0, cyc = 0, gcnt = 0;
  logic [ROW_W:0] expq [$];
  logic [ROW_W:0] mq [$];
  bit bp_mode = 0, dv_gap = 0, stuck = 0;

  nand_cache_prog_seq #(.ROW_W(ROW_W), .PAGE_BYTES(PB), .RES_DEPTH(4), .TMO_W(16)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_last(req_last), .dat_valid(dat_valid), .dat_ready(dat_ready),
    .dat_byte(dat_byte), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_wr(fl_wr), .fl_rd(fl_rd),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_rb(fl_rb),
    .res_valid(res_valid), .res_ready(res_ready), .res_row(res_row), .res_pass(res_pass),
    .tmo_limit(tmo_limit), .tmo_err(tmo_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] dbyte(int n);
    return 8'(n * 7 + 3);
  endfunction
  function automatic logic fails(logic [ROW_W-1:0] r);
    return r[0] ^ r[2];
  endfunction

  assign dat_byte = dbyte(gcnt);

  task automatic chk(bit ok, string tag, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // flash model: status bits, busy timers, byte checks
  int cbc = 0, abc = 0, n_addr = 0, n_data = 0;
  bit b1 = 0, b0 = 0, in_seq = 0, saw_cr = 0, d_ok = 1;
  logic [23:0] row_seen = '0;
  logic [ROW_W-1:0] prev_pg = '0;
  logic b6, b5;
  assign b6 = (cbc == 0) && !stuck;
  assign b5 = (abc == 0);
  assign fl_rb = b6 && b5;
  assign fl_dq_i = {1'b1, b6, b5, 3'b000, b1, b0};

  always @(negedge clk) begin
    if (rst) begin
      cbc = 0; abc = 0; in_seq = 0; saw_cr = 0;
    end else begin
      if (cbc > 0) cbc--;
      if (abc > 0) abc--;
      if (fl_wr && fl_cle) begin
        if (fl_dq_o == 8'h80) begin
          if (in_seq) chk(saw_cr, "R5 next page before cache ready", saw_cr, 1);
          n_addr = 0; n_data = 0; d_ok = 1; row_seen = '0;
        end else if (fl_dq_o == 8'h15 || fl_dq_o == 8'h10) begin
          logic [ROW_W:0] e;
          e = (mq.size() > 0) ? mq.pop_front() : '0;
          chk(n_addr == 5 && row_seen[ROW_W-1:0] == e[ROW_W:1], "R2 address cycles", row_seen, e[ROW_W:1]);
          chk(n_data == PB && d_ok, "R2 data cycles", n_data, PB);
          chk(fl_dq_o == (e[0] ? 8'h10 : 8'h15), "R3 confirm code", fl_dq_o, e[0] ? 8'h10 : 8'h15);
          b1 = in_seq ? fails(prev_pg) : 1'b1;
          if (fl_dq_o == 8'h10) begin
            b0 = fails(e[ROW_W:1]); abc = PROG; in_seq = 0;
          end else begin
            in_seq = 1;
          end
          prev_pg = e[ROW_W:1];
          cbc = CB; saw_cr = 0;
        end
      end else if (fl_wr && fl_ale) begin
        if (n_addr >= 2 && n_addr < 5) row_seen[8*(n_addr-2) +: 8] = fl_dq_o;
        else if (fl_dq_o != 8'h00) d_ok = 0;
        n_addr++;
      end else if (fl_wr) begin
        if (fl_dq_o != dbyte(gcnt)) d_ok = 0;
        n_data++;
        gcnt++;
      end
      if (fl_rd && b6) saw_cr = 1;
    end
  end

  // stimulus shaping and scoreboard monitor
  bit held = 0;
  logic [ROW_W:0] held_v;
  always @(negedge clk) begin
    dat_valid = dv_gap ? (cyc % 4 != 1) : 1'b1;
    if (held) chk(res_valid && {res_row, res_pass} == held_v, "R9 stalled result changed", {res_row, res_pass}, held_v);
    res_ready = bp_mode ? (cyc % 3 == 0) : 1'b1;
    held = 0;
    if (!rst && res_valid) begin
      if (res_ready) begin
        if (expq.size() == 0) chk(0, "R8 extra result", res_row, 0);
        else begin
          logic [ROW_W:0] e;
          e = expq.pop_front();
          chk({res_row, res_pass} == e, "R6 R7 R8 result row/pass", {res_row, res_pass}, e);
        end
      end else begin
        held = 1; held_v = {res_row, res_pass};
      end
    end
  end

  task automatic send_page(logic [ROW_W-1:0] r, bit last);
    @(negedge clk);
    req_row = r; req_last = last; req_valid = 1;
    expq.push_back({r, !fails(r)});
    mq.push_back({r, last});
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic run_seq(int n, logic [ROW_W-1:0] base, string tag);
    for (int i = 0; i < n; i++) send_page(base + ROW_W'(i * 5), i == n - 1);
    for (int w = 0; w < 5000 && (expq.size() != 0 || !req_ready); w++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(expq.size() == 0 && mq.size() == 0, tag, expq.size(), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= MAX_CYC) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, MAX_CYC);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !res_valid && !tmo_err && !fl_wr && !fl_rd, "R1 reset state",
        {req_ready, res_valid, tmo_err, fl_wr, fl_rd}, 5'b10000);

    run_seq(4, 24'h012340, "R7 R8 four-page run complete");
    run_seq(1, 24'h0A0B05, "R12 single-page run complete");
    bp_mode = 1; dv_gap = 1;
    run_seq(6, 24'h3C0001, "R8 six-page run under back-pressure");
    bp_mode = 0; dv_gap = 0;
    run_seq(2, 24'hFFFF00, "R6 two-page run complete");

    // timeout: cache never becomes ready
    tmo_limit = 16'd40;
    stuck = 1;
    expq.delete();
    send_page(24'h000777, 1'b0);
    repeat (120) @(negedge clk);
    chk(tmo_err == 1'b1, "R10 timeout flag", tmo_err, 1);
    chk(req_ready == 1'b0, "R10 no new page after timeout", req_ready, 0);
    begin
      int strobes = 0;
      for (int k = 0; k < 50; k++) begin
        @(negedge clk);
        if (fl_wr || fl_rd) strobes++;
      end
      chk(strobes == 0 && tmo_err, "R10 bus silent after timeout", strobes, 0);
    end
    chk(!res_valid, "R10 no result after timeout", res_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule